// File: doc/BRIEF.md
# System-to-Peripheral Bus Bridge

This block connects a single-clock, pipelined system bus to a simple peripheral bus. On the system bus it is a slave. On the peripheral bus it is the only master. It captures the address and direction of each accepted single-beat transfer and decodes the captured address into one select line per peripheral. Each access then runs through a fixed sequence of two cycles: a setup cycle followed by an enable cycle. The peripheral bus has no wait-state input and no response input.

While a peripheral access is in flight, the bridge stalls the system bus by holding its ready output low. For a read, it samples the selected peripheral's data at the end of the enable cycle. It returns that data in the cycle in which ready rises again. For a write, it forwards the data word that the system bus presented in its data phase. Both buses share one clock, and every state change happens on its rising edge. Reset is synchronous and active high.

Top module: `sysbus_periph_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, all select lines and `per_enable` are low, `bus_ready_out` is high, `bus_rdata` is zero and `bus_resp` is zero.
- R2: A transfer is accepted when `bus_sel` is high, `bus_ready_in` is high and `bus_trans` is 2'b10 (first beat) or 2'b11 (sequential beat). The next cycle is a setup cycle with the decoded select line high, `per_enable` low, and `per_addr` and `per_write` equal to the captured address and direction.
- R3: A setup cycle lasts exactly one cycle and is always followed by an enable cycle with `per_enable` high.
- R4: During the enable cycle, `per_addr`, `per_sel` and `per_write` hold the values they had in the setup cycle, even if the system-bus address and direction inputs change.
- R5: An enable cycle lasts exactly one cycle. If a new transfer is accepted in that cycle, the next cycle is a setup cycle. Otherwise the next cycle is idle, with every select line and `per_enable` low.
- R6: The slot number is `addr[SLOT_LSB +: SLOT_BITS]` (bits 14:12 by default). Select line i is driven when the slot number equals i, i is below NPER, and every address bit above the slot field is zero. Any other address drives no select line.
- R7: At most one select line is high in any cycle.
- R8: If `bus_sel` is low, or `bus_trans` is 2'b00 (idle) or 2'b01 (busy), the transfer is ignored. `bus_ready_out` stays high, no select line rises and `bus_rdata` keeps its value.
- R9: `bus_ready_out` goes low in the cycle after acceptance, stays low through the enable cycle, and is high again in the cycle after the enable cycle. This gives two wait states per access.
- R10: For a read, `bus_rdata` in the cycle `bus_ready_out` rises equals the selected peripheral's read data as sampled at the end of the enable cycle. If the address selected no peripheral, it is zero.
- R11: For a write, `per_wdata` during the enable cycle equals the `bus_wdata` value presented in the data phase, which is the setup cycle.
- R12: `bus_resp` is always zero (okay).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both buses |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Slave select from the system-bus address decoder |
| bus_trans | input | 2 | Transfer type: 00 idle, 01 busy, 10 first beat, 11 sequential beat |
| bus_addr | input | ADDR_W | System-bus address (address phase) |
| bus_write | input | 1 | Direction, high for a write (address phase) |
| bus_wdata | input | DATA_W | Write data (data phase) |
| bus_ready_in | input | 1 | System-bus ready seen by all slaves |
| bus_rdata | output | DATA_W | Read data returned to the system bus |
| bus_ready_out | output | 1 | Ready from this slave, low while stalling |
| bus_resp | output | 1 | Response, always okay (0) |
| per_sel | output | NPER | One-hot peripheral select lines |
| per_enable | output | 1 | High in the enable cycle of an access |
| per_write | output | 1 | Peripheral access direction |
| per_addr | output | ADDR_W | Peripheral address |
| per_wdata | output | DATA_W | Peripheral write data, valid in the enable cycle |
| per_rdata | input | NPER*DATA_W | Read data of each peripheral, slice i for line i |

## Verification
Assertions check the following on every cycle:
- A setup cycle is always followed by an enable cycle, and an enable cycle with no new request falls back to idle.
- At most one select line is high.
- Address, select and direction stay stable across the enable cycle.
- Ready falls after acceptance and rises after the enable cycle.
- Ignored transfer types leave ready high.

Only the bench's scenarios can show the rest. These are the slot decode against an independently computed map, including unmapped slots and nonzero upper bits. They also include the write data reaching the right peripheral, the read data returned from each slot, the zero returned for unmapped reads, and the behaviour of back-to-back accesses.

// File: rtl/brg_pkg.sv
package brg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ENABLE = 2'd2
  } phase_t;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;
endpackage

// File: rtl/brg_decode.sv
// Second-level decode of the registered address into one-hot selects,
// plus the read-data multiplexer steered by the same selects.
module brg_decode #(
  parameter int HI_W      = 4,   // address bits from SLOT_LSB upward
  parameter int SLOT_BITS = 3,
  parameter int NPER      = 5,
  parameter int DATA_W    = 32
) (
  input  logic [HI_W-1:0]        addr_hi,
  input  logic [NPER*DATA_W-1:0] rd_bus,
  output logic [NPER-1:0]        hit_vec,
  output logic [DATA_W-1:0]      rd_sel
);
  logic [SLOT_BITS-1:0] slot;
  logic                 upper_zero;

  assign slot = addr_hi[SLOT_BITS-1:0];

  generate
    if (HI_W > SLOT_BITS) begin : g_upper
      assign upper_zero = (addr_hi[HI_W-1:SLOT_BITS] == '0);
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NPER; i++) begin : g_line
      assign hit_vec[i] = upper_zero && (slot == SLOT_BITS'(i));
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NPER; i++) begin
      if (hit_vec[i]) rd_sel = rd_sel | rd_bus[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/brg_seq.sv
// Two-cycle peripheral access sequencer: idle -> setup -> enable.
module brg_seq
  import brg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase
);
  phase_t nxt;

  always_comb begin
    case (phase)
      PH_IDLE:   nxt = start ? PH_SETUP : PH_IDLE;
      PH_SETUP:  nxt = PH_ENABLE;
      PH_ENABLE: nxt = start ? PH_SETUP : PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end

  assert_setup_then_enable_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SETUP) |=> (phase == PH_ENABLE));

  assert_enable_to_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ENABLE && !start) |=> (phase == PH_IDLE));
endmodule

// File: rtl/brg_front.sv
// System-bus slave side: acceptance, capture of address/control/data,
// stall control and read-data return.
module brg_front
  import brg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic [1:0]        bus_trans,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready_in,
  input  phase_t            phase,
  input  logic [DATA_W-1:0] rd_sel,
  output logic              start,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ready_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic active_type;

  assign active_type = (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);
  assign start       = bus_sel && active_type && bus_ready_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      ready_q <= 1'b1;
      rdata_q <= '0;
    end else begin
      if (phase == PH_SETUP) wdata_q <= bus_wdata;
      if (phase == PH_ENABLE) begin
        ready_q <= 1'b1;
        rdata_q <= write_q ? '0 : rd_sel;
      end
      if (start) begin
        addr_q  <= bus_addr;
        write_q <= bus_write;
        ready_q <= 1'b0;
      end
    end
  end

  assert_stall_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready_q);

  assert_ignored_no_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_q && bus_ready_in && !(bus_sel && active_type)) |=> ready_q);
endmodule

// File: rtl/sysbus_periph_bridge.sv
module sysbus_periph_bridge
  import brg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NPER      = 5,
  parameter int SLOT_LSB  = 12,
  parameter int SLOT_BITS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_sel,
  input  logic [1:0]             bus_trans,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_write,
  input  logic [DATA_W-1:0]      bus_wdata,
  input  logic                   bus_ready_in,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_ready_out,
  output logic                   bus_resp,
  output logic [NPER-1:0]        per_sel,
  output logic                   per_enable,
  output logic                   per_write,
  output logic [ADDR_W-1:0]      per_addr,
  output logic [DATA_W-1:0]      per_wdata,
  input  logic [NPER*DATA_W-1:0] per_rdata
);
  localparam int HI_W = ADDR_W - SLOT_LSB;

  phase_t            phase;
  logic              start;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [NPER-1:0]   hit_vec;
  logic [DATA_W-1:0] rd_sel;

  brg_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_trans(bus_trans),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_ready_in(bus_ready_in), .phase(phase), .rd_sel(rd_sel),
    .start(start), .addr_q(addr_q), .write_q(write_q), .wdata_q(wdata_q),
    .ready_q(bus_ready_out), .rdata_q(bus_rdata)
  );

  brg_seq u_seq (.clk(clk), .rst(rst), .start(start), .phase(phase));

  brg_decode #(.HI_W(HI_W), .SLOT_BITS(SLOT_BITS), .NPER(NPER), .DATA_W(DATA_W)) u_dec (
    .addr_hi(addr_q[ADDR_W-1:SLOT_LSB]), .rd_bus(per_rdata),
    .hit_vec(hit_vec), .rd_sel(rd_sel)
  );

  assign per_sel    = (phase != PH_IDLE) ? hit_vec : '0;
  assign per_enable = (phase == PH_ENABLE);
  assign per_write  = write_q;
  assign per_addr   = addr_q;
  assign per_wdata  = wdata_q;
  assign bus_resp   = 1'b0;

  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(per_sel));

  assert_enable_holds_R4: assert property (@(posedge clk) disable iff (rst)
    per_enable |-> ($stable(per_addr) && $stable(per_sel) && $stable(per_write)));

  assert_ready_after_enable_R9: assert property (@(posedge clk) disable iff (rst)
    per_enable |=> bus_ready_out);
endmodule

// File: tb/sysbus_periph_bridge_test.sv
`timescale 1ns/1ps
module sysbus_periph_bridge_test;
  localparam int AW = 16, DW = 32, NP = 5, SL = 12, SB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0;
  logic [1:0] bus_trans = 2'b00;
  logic [AW-1:0] bus_addr = '0;
  logic bus_write = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ready_in;
  logic [DW-1:0] bus_rdata;
  logic bus_ready_out, bus_resp;
  logic [NP-1:0] per_sel;
  logic per_enable, per_write;
  logic [AW-1:0] per_addr;
  logic [DW-1:0] per_wdata;
  logic [NP*DW-1:0] per_rdata;

  logic [DW-1:0] per_mem [NP];
  logic [DW-1:0] exp_mem [NP];
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  assign bus_ready_in = bus_ready_out;

  sysbus_periph_bridge #(.ADDR_W(AW), .DATA_W(DW), .NPER(NP), .SLOT_LSB(SL), .SLOT_BITS(SB)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_trans(bus_trans), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_ready_in(bus_ready_in),
    .bus_rdata(bus_rdata), .bus_ready_out(bus_ready_out), .bus_resp(bus_resp),
    .per_sel(per_sel), .per_enable(per_enable), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
  );

  // peripheral models: one register each
  always_comb begin
    for (int i = 0; i < NP; i++) per_rdata[i*DW +: DW] = per_mem[i];
  end

  always @(negedge clk) begin
    for (int i = 0; i < NP; i++)
      if (per_sel[i] && per_enable && per_write) per_mem[i] <= per_wdata;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_run = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access. Call just after a negedge; returns just after the negedge of
  // the cycle in which ready is high again.
  task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                      input logic [1:0] tr);
    int idx;
    logic hit;
    logic [NP-1:0] es;
    idx = int'(a[SL +: SB]);
    hit = (a[AW-1:SL+SB] == '0) && (idx < NP);
    es  = hit ? (NP'(1) << idx) : '0;
    bus_sel = 1'b1; bus_trans = tr; bus_addr = a; bus_write = wr;
    @(negedge clk); // setup / data phase
    bus_wdata = wd; bus_sel = 1'b0; bus_trans = 2'b00; bus_addr = ~a; bus_write = ~wr;
    chk(per_sel == es, "R2 R6 select", 64'(per_sel), 64'(es));
    chk(!per_enable, "R2 enable low in setup", 64'(per_enable), 64'd0);
    chk(per_addr == a, "R2 addr", 64'(per_addr), 64'(a));
    chk(per_write == wr, "R2 dir", 64'(per_write), 64'(wr));
    chk(!bus_ready_out, "R9 stall setup", 64'(bus_ready_out), 64'd0);
    chk(bus_resp == 1'b0, "R12 resp", 64'(bus_resp), 64'd0);
    @(negedge clk); // enable
    bus_wdata = ~wd;
    chk(per_enable, "R3 enable", 64'(per_enable), 64'd1);
    chk(per_sel == es, "R4 sel held", 64'(per_sel), 64'(es));
    chk(per_addr == a && per_write == wr, "R4 addr dir held", 64'(per_addr), 64'(a));
    chk(!bus_ready_out, "R9 stall enable", 64'(bus_ready_out), 64'd0);
    if (wr) chk(per_wdata == wd, "R11 wdata", 64'(per_wdata), 64'(wd));
    if (wr && hit) exp_mem[idx] = wd;
    @(negedge clk); // ready again
    chk(bus_ready_out, "R9 ready back", 64'(bus_ready_out), 64'd1);
    chk(per_sel == '0 && !per_enable, "R5 idle after enable", 64'(per_sel), 64'd0);
    if (!wr) chk(bus_rdata == (hit ? exp_mem[idx] : '0), "R10 rdata", 64'(bus_rdata),
                 64'(hit ? exp_mem[idx] : '0));
  endtask

  task automatic ign(input logic s, input logic [1:0] tr, input logic [AW-1:0] a);
    logic [DW-1:0] prev;
    prev = bus_rdata;
    bus_sel = s; bus_trans = tr; bus_addr = a; bus_write = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_trans = 2'b00;
    chk(bus_ready_out, "R8 ready kept", 64'(bus_ready_out), 64'd1);
    chk(per_sel == '0 && !per_enable, "R8 no select", 64'(per_sel), 64'd0);
    @(negedge clk);
    chk(per_sel == '0 && bus_ready_out, "R8 still idle", 64'(per_sel), 64'd0);
    chk(bus_rdata == prev, "R8 rdata kept", 64'(bus_rdata), 64'(prev));
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin per_mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk(per_sel == '0 && !per_enable, "R1 reset selects", 64'(per_sel), 64'd0);
    chk(bus_ready_out && bus_rdata == '0 && !bus_resp, "R1 reset ready",
        64'(bus_ready_out), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_ready_out && per_sel == '0, "R1 after reset", 64'(bus_ready_out), 64'd1);

    // writes over all slots, with and without the upper address bit
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 8; s++)
        xfer({t[0], s[2:0], 12'(s * 4 + t * 8)}, 1'b1,
             32'hA5000000 ^ (32'(s) * 32'h01010101) ^ 32'(t << 20), 2'b10);
    // reads back: mapped slots return last mapped write, others zero
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 8; s++)
        xfer({t[0], s[2:0], 12'h010}, 1'b0, '0, 2'b10);

    // sequential-beat type accepted, back-to-back accesses
    xfer(16'h2004, 1'b1, 32'h1234_5678, 2'b11);
    xfer(16'h2008, 1'b0, '0, 2'b11);
    xfer(16'h4000, 1'b1, 32'hCAFE_F00D, 2'b10);
    xfer(16'h4000, 1'b0, '0, 2'b10);
    xfer(16'h7000, 1'b0, '0, 2'b10);

    // ignored transfers
    xfer(16'h1000, 1'b0, '0, 2'b10);
    ign(1'b1, 2'b00, 16'h1000);
    ign(1'b1, 2'b01, 16'h2000);
    ign(1'b0, 2'b10, 16'h3000);
    ign(1'b0, 2'b11, 16'h0000);
    for (int i = 0; i < NP; i++)
      chk(per_mem[i] == exp_mem[i], "R8 R11 peripheral contents", 64'(per_mem[i]), 64'(exp_mem[i]));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule